// File: doc/BRIEF.md
# Push-pull gate drive steering logic

This block sits between a pulse-width modulator and two power-switch gate drivers. It takes one single-ended drive request, given as a non-inverting and an inverting input, and turns it into two registered gate-drive enables, A and B. In alternating mode an internal toggle sends successive pulses to A and B in turn, which gives push-pull drive from a single-ended modulator. In parallel mode both enables follow the request together, so the two drivers can share one load.

A new pulse is accepted only after the request has been inactive for a minimum off-time, counted in clock cycles. This keeps a short dropout in the request from advancing the toggle twice. The block also applies three protections. A stop input from an external current comparator sets a shutdown latch. That latch is released only between pulses. An over-temperature condition holds both enables low. Each channel has an inhibit that delays its turn-on while the opposite switch is still conducting. All of these arrive as synchronous digital flags. Every input passes through a two-flop synchroniser, and the enables come straight from flip-flops.

Top module: `pp_gate_steer`

## Requirements
- R1: The internal request is active only while `req_hi_i`=1 and `req_lo_n_i`=0. Any other combination leaves both enables low. If `req_lo_n_i` falls while `req_hi_i` is already high, that counts as a request rising edge.
- R2: With `alt_en_i`=1 sampled at the start of a pulse, that pulse drives only one enable. Successive accepted pulses go A, B, A, B. The two enables are never high together during such a pulse.
- R3: With `alt_en_i`=0 sampled at the start of a pulse, `drv_a_o` and `drv_b_o` both follow the request. Such a pulse does not advance the A/B toggle.
- R4: A pulse starts only if the request was low for at least OFF_CYCLES consecutive clock cycles. A gap of exactly OFF_CYCLES cycles qualifies. A gap of OFF_CYCLES-1 cycles starts no pulse and leaves the toggle unchanged, and the enables stay low until the request has been low for a full off-time again.
- R5: A high on `stop_i` ends any pulse and sets a shutdown latch that holds both enables low. The latch clears only once `stop_i` is low and the request has been low for OFF_CYCLES cycles. A pulse cut short by the stop still counts for the toggle.
- R6: In the default two-flag variant, `ot_set_i`=1 sets an over-temperature state and `ot_clr_i`=1 clears it, with set taking priority when both are high. While that state is set, both enables are low, any running pulse ends, and no pulse starts. A pulse blocked in this way does not resume when the state clears. With OT_SINGLE_FLAG=1, `ot_set_i` is taken directly as the over-temperature level and `ot_clr_i` is ignored.
- R7: While `inh_a_i`=1 (or `inh_b_i`=1), that enable cannot go from low to high. It rises 3 cycles after the inhibit drops if the pulse is still running. An inhibit that rises while the enable is already high does not turn it off.
- R8: A synchronous reset (`rst_i`=1) clears both enables, the synchronisers, the shutdown latch, the over-temperature state and the off-time count, and points the toggle at A. The first pulse after reset needs a full off-time first and then goes to A.
- R9: Every input reaches the enables exactly three rising clock edges after it is applied: two synchroniser stages, then the output register. The enables are driven directly by flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_hi_i | input | 1 | Non-inverting drive request |
| req_lo_n_i | input | 1 | Inverting drive request |
| alt_en_i | input | 1 | 1: alternate A/B, 0: parallel drive |
| stop_i | input | 1 | Stop comparator flag, sets the shutdown latch |
| ot_set_i | input | 1 | Over-temperature assert flag (or level in single-flag variant) |
| ot_clr_i | input | 1 | Over-temperature release flag |
| inh_a_i | input | 1 | Turn-on inhibit for channel A |
| inh_b_i | input | 1 | Turn-on inhibit for channel B |
| drv_a_o | output | 1 | Gate-drive enable A |
| drv_b_o | output | 1 | Gate-drive enable B |

## Verification
The assertions check the following on every cycle:
- the stop and over-temperature states always force both enables low;
- an alternating pulse never raises both enables;
- an enable is high only after a synchronised request;
- a pulse begins only while the off-time is qualified;
- no enable rises under its own inhibit.

Some behaviour only the bench scenarios can show, because it depends on sequences of pulses. This covers the A/B order across pulses, and the fact that a gap one cycle short of the off-time leaves the toggle unchanged. It also covers when the shutdown latch is released, and the fact that a pulse blocked by over-temperature does not resume. The random phase compares both enables every cycle against a cycle model driven from inputs delayed by the three-edge latency.

// File: rtl/pp_steer_pkg.sv
package pp_steer_pkg;

    // Synchronised input flags, in synchroniser bit order (MSB first).
    typedef struct packed {
        logic req_p;
        logic req_n;
        logic alt;
        logic stop;
        logic ot_set;
        logic ot_clr;
        logic inh_a;
        logic inh_b;
    } flag_t;

    localparam int FLAG_W = $bits(flag_t);

    // Registered state of the steering core.
    typedef struct packed {
        logic active;    // a pulse is running
        logic par;       // running pulse is a parallel pulse
        logic on_b;      // running alternating pulse belongs to channel B
        logic next_b;    // toggle: next alternating pulse goes to B
        logic stop_lat;  // shutdown latch
        logic ot;        // over-temperature state
        logic out_a;
        logic out_b;
    } core_t;

    localparam core_t CORE_RESET = '0;

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_d;
    logic [STAGES-1:0][W-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[g] = d_i;
        end else begin : g_next
            assign chain_d[g] = chain_q[g-1];
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                chain_q[g] <= '0;
            end else begin
                chain_q[g] <= chain_d[g];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pp_offtime_qual.sv
module pp_offtime_qual #(
    parameter int OFF_CYCLES = 10
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_i,
    output logic armed_o
);

    localparam int               CNT_W   = $clog2(OFF_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(OFF_CYCLES);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    // Counts low cycles of the request, saturating at the off-time.
    always_comb begin
        cnt_d = cnt_q;
        if (req_i) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign armed_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/pp_steer_core.sv
module pp_steer_core
    import pp_steer_pkg::*;
#(
    parameter bit OT_SINGLE_FLAG = 1'b0
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  flag_t flags_i,
    input  logic  armed_i,
    output logic  req_o,
    output logic  drv_a_o,
    output logic  drv_b_o
);

    core_t st_d;
    core_t st_q;
    logic  req;
    logic  ot_nx;
    logic  kill;
    logic  start;
    logic  want_a;
    logic  want_b;
    logic  ot_clr_seen;

    assign req = flags_i.req_p & ~flags_i.req_n;

    // Variant: over-temperature as a ready-made level or as set/release flags.
    if (OT_SINGLE_FLAG) begin : g_ot_level
        assign ot_nx       = flags_i.ot_set;
        assign ot_clr_seen = flags_i.ot_clr & 1'b0;
    end else begin : g_ot_pair
        assign ot_nx       = flags_i.ot_set | (st_q.ot & ~flags_i.ot_clr);
        assign ot_clr_seen = 1'b0;
    end

    assign kill  = flags_i.stop | st_q.stop_lat | ot_nx | ot_clr_seen;
    assign start = req & ~st_q.active & armed_i & ~kill;

    always_comb begin
        st_d    = st_q;
        st_d.ot = ot_nx;

        // Shutdown latch: set by stop, released between qualified pulses.
        st_d.stop_lat = flags_i.stop | (st_q.stop_lat & ~(armed_i & ~req));

        if (start) begin
            st_d.active = 1'b1;
            st_d.par    = ~flags_i.alt;
            st_d.on_b   = flags_i.alt & st_q.next_b;
            st_d.next_b = flags_i.alt ? ~st_q.next_b : st_q.next_b;
        end else if (!req || kill) begin
            st_d.active = 1'b0;
        end

        want_a = st_d.active & (st_d.par | ~st_d.on_b);
        want_b = st_d.active & (st_d.par | st_d.on_b);

        // Inhibit only holds off a rising edge.
        st_d.out_a = want_a & (st_q.out_a | ~flags_i.inh_a);
        st_d.out_b = want_b & (st_q.out_b | ~flags_i.inh_b);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= CORE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o   = req;
    assign drv_a_o = st_q.out_a;
    assign drv_b_o = st_q.out_b;

endmodule

// File: rtl/pp_gate_steer.sv
module pp_gate_steer
    import pp_steer_pkg::*;
#(
    parameter int OFF_CYCLES     = 10,
    parameter int SYNC_STAGES    = 2,
    parameter bit OT_SINGLE_FLAG = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_hi_i,
    input  logic req_lo_n_i,
    input  logic alt_en_i,
    input  logic stop_i,
    input  logic ot_set_i,
    input  logic ot_clr_i,
    input  logic inh_a_i,
    input  logic inh_b_i,
    output logic drv_a_o,
    output logic drv_b_o
);

    flag_t             raw_flags;
    logic [FLAG_W-1:0] sync_vec;
    flag_t             sync_flags;
    logic              req_s;
    logic              armed;

    assign raw_flags = '{req_p:  req_hi_i,
                         req_n:  req_lo_n_i,
                         alt:    alt_en_i,
                         stop:   stop_i,
                         ot_set: ot_set_i,
                         ot_clr: ot_clr_i,
                         inh_a:  inh_a_i,
                         inh_b:  inh_b_i};

    pp_sync #(
        .W      (FLAG_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_flags),
        .q_o   (sync_vec)
    );

    assign sync_flags = flag_t'(sync_vec);

    pp_offtime_qual #(
        .OFF_CYCLES (OFF_CYCLES)
    ) offq_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .req_i   (req_s),
        .armed_o (armed)
    );

    pp_steer_core #(
        .OT_SINGLE_FLAG (OT_SINGLE_FLAG)
    ) core_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .flags_i (sync_flags),
        .armed_i (armed),
        .req_o   (req_s),
        .drv_a_o (drv_a_o),
        .drv_b_o (drv_b_o)
    );

endmodule

// File: rtl/pp_gate_steer_chk.sv
module pp_gate_steer_chk (
    input logic clk_i,
    input logic rst_i,
    input logic drv_a,
    input logic drv_b,
    input logic req_s,
    input logic stop_s,
    input logic stop_lat_q,
    input logic ot_q,
    input logic par_q,
    input logic active_q,
    input logic armed,
    input logic inh_a_s,
    input logic inh_b_s
);

    // R1: an enable is high only after a synchronised request
    p_req_gate_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (drv_a || drv_b) |-> $past(req_s));

    // R2: an alternating pulse never drives both enables
    p_excl_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !par_q |-> !(drv_a && drv_b));

    // R4: a pulse begins only when the off-time was qualified
    p_start_armed_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(active_q) |-> $past(armed));

    // R5: a stop flag forces both enables low on the next edge
    p_stop_kill_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        stop_s |=> (!drv_a && !drv_b));

    // R5: the shutdown latch holds both enables low
    p_latch_low_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        stop_lat_q |-> (!drv_a && !drv_b));

    // R6: over-temperature holds both enables low
    p_ot_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ot_q |-> (!drv_a && !drv_b));

    // R7: no enable rises under its own inhibit
    p_inh_a_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(drv_a) |-> $past(!inh_a_s));
    p_inh_b_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(drv_b) |-> $past(!inh_b_s));

endmodule

bind pp_steer_core pp_gate_steer_chk chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .drv_a      (drv_a_o),
    .drv_b      (drv_b_o),
    .req_s      (req),
    .stop_s     (flags_i.stop),
    .stop_lat_q (st_q.stop_lat),
    .ot_q       (st_q.ot),
    .par_q      (st_q.par),
    .active_q   (st_q.active),
    .armed      (armed_i),
    .inh_a_s    (flags_i.inh_a),
    .inh_b_s    (flags_i.inh_b)
);

// File: tb/pp_gate_steer_tb_top.sv
module pp_gate_steer_tb_top;

    localparam int N = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rp = 0, rn = 0, alt = 1, stp = 0, ots = 0, otc = 0, ia = 0, ib = 0;
    logic drv_a, drv_b;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    bit  cmp_en = 0;

    always #10 clk = ~clk;  // 50 MHz

    pp_gate_steer #(.OFF_CYCLES(N)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .req_hi_i   (rp),
        .req_lo_n_i (rn),
        .alt_en_i   (alt),
        .stop_i     (stp),
        .ot_set_i   (ots),
        .ot_clr_i   (otc),
        .inh_a_i    (ia),
        .inh_b_i    (ib),
        .drv_a_o    (drv_a),
        .drv_b_o    (drv_b)
    );

    // Cycle model from the requirements, fed by inputs delayed two edges.
    bit [7:0] m_d1, m_d2;
    bit m_act, m_par, m_onb, m_nextb, m_stop, m_ot, m_a, m_b;
    int m_cnt;
    bit m_req, m_armed, m_otn, m_kill, m_start, m_wa, m_wb;

    always @(posedge clk) begin
        if (rst) begin
            m_d1 = '0; m_d2 = '0; m_cnt = 0;
            {m_act, m_par, m_onb, m_nextb, m_stop, m_ot, m_a, m_b} = '0;
        end else begin
            m_req   = m_d2[7] & ~m_d2[6];
            m_armed = (m_cnt >= N);
            m_otn   = m_d2[3] | (m_ot & ~m_d2[2]);
            m_kill  = m_d2[4] | m_stop | m_otn;
            m_start = m_req & ~m_act & m_armed & ~m_kill;
            m_ot    = m_otn;
            m_stop  = m_d2[4] | (m_stop & ~(m_armed & ~m_req));
            if (m_start) begin
                m_act = 1; m_par = ~m_d2[5];
                m_onb = m_d2[5] & m_nextb;
                if (m_d2[5]) m_nextb = ~m_nextb;
            end else if (!m_req || m_kill) begin
                m_act = 0;
            end
            m_wa = m_act & (m_par | ~m_onb);
            m_wb = m_act & (m_par | m_onb);
            m_a  = m_wa & (m_a | ~m_d2[1]);
            m_b  = m_wb & (m_b | ~m_d2[0]);
            if (m_req) m_cnt = 0; else if (m_cnt < N) m_cnt++;
            m_d2 = m_d1;
            m_d1 = {rp, rn, alt, stp, ots, otc, ia, ib};
        end
    end

    task automatic chk(input string tag, input logic [1:0] exp);
        checks++;
        if ({drv_a, drv_b} !== exp) begin
            fails++;
            $display("FAIL %s: a/b=%b expected %b at %0t", tag, {drv_a, drv_b}, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R9: watchdog expired, got done=0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        tick(3);
        chk("R8 outputs low in reset", 2'b00);
        rst = 0;
        // R8: no pulse before a full off-time after reset
        rp = 1; tick(3); chk("R8 not armed after reset", 2'b00);
        tick(2); chk("R8 still low", 2'b00);
        rp = 0; tick(20);
        // first pulse: latency and channel A
        rp = 1; tick(2); chk("R9 no output after two edges", 2'b00);
        tick(1); chk("R2 first pulse to A", 2'b10);
        rp = 0; tick(3); chk("R2 pulse end", 2'b00);
        tick(15);
        rp = 1; tick(3); chk("R2 second pulse to B", 2'b01);
        rp = 0; tick(15);
        // R1: combine of the two request inputs
        rp = 1; rn = 1; tick(4); chk("R1 inverting input blocks", 2'b00);
        rn = 0; tick(3); chk("R1 inverting release starts pulse A", 2'b10);
        rp = 0; tick(15);
        // R4: off-time qualification
        rp = 1; tick(3); chk("R4 pulse to B", 2'b01);
        tick(2); rp = 0; tick(N - 1); rp = 1;
        tick(3); chk("R4 short gap ignored", 2'b00);
        tick(3); chk("R4 short gap stays low", 2'b00);
        rp = 0; tick(15);
        rp = 1; tick(3); chk("R4 toggle not advanced by short gap", 2'b10);
        rp = 0; tick(N); rp = 1;
        tick(3); chk("R4 gap of exactly N qualifies", 2'b01);
        rp = 0; tick(15);
        // R3: parallel mode
        alt = 0; tick(1);
        rp = 1; tick(3); chk("R3 parallel both on", 2'b11);
        rp = 0; tick(3); chk("R3 parallel both off", 2'b00);
        alt = 1; tick(15);
        rp = 1; tick(3); chk("R3 parallel did not advance toggle", 2'b10);
        rp = 0; tick(15);
        // R7: inhibit
        ib = 1; rp = 1; tick(3); chk("R7 inhibit holds B off", 2'b00);
        tick(3); chk("R7 inhibit still holds", 2'b00);
        ib = 0; tick(3); chk("R7 B turns on after inhibit drops", 2'b01);
        ib = 1; tick(4); chk("R7 inhibit does not turn B off", 2'b01);
        rp = 0; tick(3); chk("R7 B off at request end", 2'b00);
        ib = 0; tick(15);
        // R5: stop latch
        rp = 1; tick(3); chk("R5 pulse A before stop", 2'b10);
        stp = 1; tick(1); stp = 0; tick(2); chk("R5 stop forces low", 2'b00);
        tick(5); chk("R5 latch holds while request high", 2'b00);
        rp = 0; tick(4); rp = 1; tick(3); chk("R5 latch holds after short gap", 2'b00);
        rp = 0; tick(15);
        rp = 1; tick(3); chk("R5 released, stopped pulse counted", 2'b01);
        rp = 0; tick(15);
        // R6: over-temperature
        ots = 1; tick(1); ots = 0; tick(2);
        rp = 1; tick(3); chk("R6 over-temperature blocks start", 2'b00);
        otc = 1; tick(1); otc = 0; tick(5); chk("R6 blocked pulse not resumed", 2'b00);
        rp = 0; tick(15);
        rp = 1; tick(3); chk("R6 after release, pulse A", 2'b10);
        ots = 1; otc = 1; tick(1); ots = 0; otc = 0; tick(2);
        chk("R6 set wins over release, pulse ended", 2'b00);
        rp = 0; otc = 1; tick(1); otc = 0; tick(15);
        rp = 1; tick(3); chk("R6 next pulse to B", 2'b01);
        rp = 0; tick(15);
        // random phase against the cycle model
        cmp_en = 1;
        begin
            int seg = 0;
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                chk("R9 model compare", {m_a, m_b});
                if (seg == 0) begin
                    rp  = ~rp;
                    seg = rp ? 1 + int'($urandom % 8) : 1 + int'($urandom % (2 * N));
                end
                seg--;
                rn  = ($urandom % 12 == 0);
                stp = ($urandom % 90 == 0);
                ots = ($urandom % 150 == 0);
                otc = ($urandom % 15 == 0);
                ia  = ($urandom % 4 == 0);
                ib  = ($urandom % 4 == 0);
                if ($urandom % 60 == 0) alt = ~alt;
            end
        end
        done = 1;
        summary();
        $finish;
    end

endmodule